// File: doc/BRIEF.md
# Masked Breakpoint Comparator with Coast Counter

This block watches the bus cycles of a target processor and raises a one-clock break request. Each bus cycle is presented as a 32-bit compare word. Bits 31:16 carry the address, bits 15:8 carry the processor status and bits 7:0 carry the user hardware status. A strobe marks the cycles that are valid. A set of one-hot event flags says what kind of cycle it is.

There are two breakpoint slots. Each slot holds a 32-bit value and a 32-bit care mask. A care bit of 1 makes the word bit compare against the value bit. A care bit of 0 makes that word bit a don't-care. In direct mode a slot breaks on the cycle after a match. In coast mode a match arms the slot with a count n, and the slot then waits for n further events of a chosen class before it breaks.

After any break the block stays quiet until the enable input is dropped and raised again. Configuration arrives on plain register-style input ports. Halting the processor and host access are left to the surrounding logic.

Top module: `brk_coast_unit`

## Requirements
- R1: `bp_match[b]` is high in the same cycle exactly when `cyc_valid` is high and, for every bit where `bp_care[b]` is 1, `cyc_word` equals `bp_value[b]`. Bits with care 0 never affect the result.
- R2: With `enable` high and the block not tripped, a match on a slot with `bp_coast[b]`=0 in cycle t makes `brk_pulse` high in cycle t+1 for one clock, with `brk_src[b]`=1.
- R3: In coast mode a match loads the count `bp_count[b]`. Qualifying events in later cycles each count down by one, and an event in the arming cycle itself does not count. `brk_pulse` is high in the cycle after the n-th event.
- R4: The class code `bp_class[b]` selects the counted event: 0 instruction fetch (`ev_flags[0]`), 1 I/O read (`ev_flags[1]`), 2 interrupt acknowledge (`ev_flags[2]`), 3 serial input (`ev_flags[3]`), 4 serial output (`ev_flags[4]`), 5 any of these. Codes 6 and 7 never count.
- R5: The classes interrupt acknowledge, serial input and serial output count only when their availability bits are 1 (`ev_avail[0]`, `ev_avail[1]`, `ev_avail[2]`). The same gating applies inside class 5.
- R6: In coast mode an arming match with `bp_count[b]`=0 is ignored: the slot does not arm and does not break.
- R7: A match on a slot that is already coasting does not reload its count.
- R8: After a break the block is tripped. No further break occurs until `enable` has been low for at least one cycle and high again. Dropping `enable` also clears every armed slot.
- R9: After reset `brk_pulse` and `brk_src` are 0 and no slot is armed. No break occurs while `enable` is low.
- R10: Event flags on cycles with `cyc_valid` low never count.
- R11: When both slots fire in the same cycle, a single pulse is produced with both `brk_src` bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Break enable; a low cycle re-opens the block after a break |
| bp_value | input | 2x32 | Compare value per slot |
| bp_care | input | 2x32 | Care mask per slot (1 = compare bit) |
| bp_coast | input | 2 | Per slot: 1 = coast mode, 0 = direct |
| bp_class | input | 2x3 | Coast event class code per slot |
| bp_count | input | 2x8 | Coast count n per slot (0 invalid) |
| cyc_word | input | 32 | Compare word of the current bus cycle |
| cyc_valid | input | 1 | Bus cycle valid strobe |
| ev_flags | input | 5 | Event flags: fetch, I/O read, int ack, serial in, serial out |
| ev_avail | input | 3 | Availability of int ack, serial in, serial out status |
| bp_match | output | 2 | Per-slot match flag for the current cycle |
| brk_pulse | output | 1 | One-clock break request |
| brk_src | output | 2 | Slots that caused the break, valid with brk_pulse |

## Verification
The comparator is driven with an exact match, a mismatch on a cared bit, a mismatch on a don't-care bit and a matching word with the strobe low. These four cases separate mask handling from valid gating. Coast runs interleave counted and uncounted event kinds, put an event in the arming cycle, re-match while coasting and use a zero count. Each of these would shift the break cycle, or make a break appear where none should, if counting or arming were wrong. Availability, the never-counting codes and the strobe-low events are each run against an otherwise firing setup. The bench also fires both slots at once and fires again before and after an enable toggle, which exposes missing trip or clear logic.

// File: rtl/brk_pkg.sv
// Package: shared constants and the coast event class encoding.
package brk_pkg;
    localparam int NUM_EV = 5;   // fetch, io read, int ack, serial in, serial out
    localparam int NUM_AV = 3;   // availability bits for the last three classes
    localparam int CLS_W  = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_FETCH = 3'd0,
        CLS_IORD  = 3'd1,
        CLS_INTA  = 3'd2,
        CLS_SIN   = 3'd3,
        CLS_SOUT  = 3'd4,
        CLS_ANY   = 3'd5,
        CLS_OFF6  = 3'd6,
        CLS_OFF7  = 3'd7
    } ev_cls_e;
endpackage

// File: rtl/brk_match.sv
// Masked comparator for one breakpoint slot.
// Every word bit is either cared (it must equal the value bit) or ignored.
// Assumes the word, value and mask are stable in the cycle they are sampled.
module brk_match #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] value_i,
    input  logic [WORD_W-1:0] care_i,
    input  logic              valid_i,
    output logic              hit_o
);
    logic [WORD_W-1:0] bit_ok;

    // Per-bit test: equal, or masked out.
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign bit_ok[i] = ~(word_i[i] ^ value_i[i]) | ~care_i[i];
    end

    // A slot matches only on a valid cycle with every bit passing.
    assign hit_o = valid_i & (&bit_ok);
endmodule

// File: rtl/brk_event_sel.sv
// Coast event qualifier for one slot.
// Picks the event class given by the class code, and gates the classes
// that need processor status with their availability bits.
// Assumes the event flags belong to the cycle marked by valid_i.
module brk_event_sel
    import brk_pkg::*;
(
    input  logic [NUM_EV-1:0] ev_i,
    input  logic [NUM_AV-1:0] avail_i,
    input  logic              valid_i,
    input  logic [CLS_W-1:0]  cls_i,
    output logic              qual_o
);
    logic [NUM_EV-1:0] ev_eff;
    logic              pick;

    // Mask out events whose status the processor does not supply.
    assign ev_eff = ev_i & {avail_i, 2'b11};

    // Class decode; unused codes never qualify.
    always_comb begin
        unique case (ev_cls_e'(cls_i))
            CLS_FETCH: pick = ev_eff[0];
            CLS_IORD:  pick = ev_eff[1];
            CLS_INTA:  pick = ev_eff[2];
            CLS_SIN:   pick = ev_eff[3];
            CLS_SOUT:  pick = ev_eff[4];
            CLS_ANY:   pick = |ev_eff;
            default:   pick = 1'b0;
        endcase
    end

    // Events outside valid cycles never count.
    assign qual_o = valid_i & pick;
endmodule

// File: rtl/brk_coast.sv
// Arm and count state for one breakpoint slot.
// In direct mode fire_o follows the match. In coast mode a match with a
// nonzero count arms the slot, and later qualifying events count down.
// fire_o is high in the cycle of the final event.
// Assumes halt_i is the block-wide tripped flag.
module brk_coast #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             halt_i,
    input  logic             coast_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             hit_i,
    input  logic             qual_i,
    output logic             fire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic             run;

    assign run = enable_i & ~halt_i;

    // Fire decision for this cycle.
    always_comb begin
        if (!run)
            fire_o = 1'b0;
        else if (coast_i)
            fire_o = armed & qual_i & (cnt == ONE);
        else
            fire_o = hit_i;
    end

    // Arm on a first match, count down on qualifying events, drop on fire or halt.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (halt_i) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (armed) begin
            if (qual_i) begin
                if (cnt == ONE) begin
                    armed <= 1'b0;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end else if (coast_i && hit_i && (count_i != '0)) begin
            armed <= 1'b1;
            cnt   <= count_i;
        end
    end
endmodule

// File: rtl/brk_coast_unit.sv
// Top: breakpoint slots with masked compare and coast counting.
// Combines the slot fires into one registered break pulse with source
// flags, and trips until enable is toggled.
// Assumes the configuration ports are steady while enable is high.
module brk_coast_unit
    import brk_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable,
    input  logic [NUM_BP-1:0][WORD_W-1:0] bp_value,
    input  logic [NUM_BP-1:0][WORD_W-1:0] bp_care,
    input  logic [NUM_BP-1:0]            bp_coast,
    input  logic [NUM_BP-1:0][CLS_W-1:0] bp_class,
    input  logic [NUM_BP-1:0][CNT_W-1:0] bp_count,
    input  logic [WORD_W-1:0]            cyc_word,
    input  logic                         cyc_valid,
    input  logic [NUM_EV-1:0]            ev_flags,
    input  logic [NUM_AV-1:0]            ev_avail,
    output logic [NUM_BP-1:0]            bp_match,
    output logic                         brk_pulse,
    output logic [NUM_BP-1:0]            brk_src
);
    logic [NUM_BP-1:0] qual;
    logic [NUM_BP-1:0] fire;
    logic              tripped;

    for (genvar b = 0; b < NUM_BP; b++) begin : g_slot
        brk_match #(.WORD_W(WORD_W)) i_match (
            .word_i  (cyc_word),
            .value_i (bp_value[b]),
            .care_i  (bp_care[b]),
            .valid_i (cyc_valid),
            .hit_o   (bp_match[b])
        );

        brk_event_sel i_sel (
            .ev_i    (ev_flags),
            .avail_i (ev_avail),
            .valid_i (cyc_valid),
            .cls_i   (bp_class[b]),
            .qual_o  (qual[b])
        );

        brk_coast #(.CNT_W(CNT_W)) i_coast (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable_i (enable),
            .halt_i   (tripped),
            .coast_i  (bp_coast[b]),
            .count_i  (bp_count[b]),
            .hit_i    (bp_match[b]),
            .qual_i   (qual[b]),
            .fire_o   (fire[b])
        );
    end

    // Trip latch: set by any fire, cleared only by dropping enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            tripped <= 1'b0;
        else if (|fire)
            tripped <= 1'b1;
    end

    // Registered break pulse and source flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_pulse <= 1'b0;
            brk_src   <= '0;
        end else begin
            brk_pulse <= |fire;
            brk_src   <= fire;
        end
    end
endmodule

// File: rtl/brk_coast_chk.sv
// Checker for brk_coast_unit: port and trip-state properties.
// It is bound to every instance of the top.
module brk_coast_chk #(
    parameter int NUM_BP = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              cyc_valid,
    input logic [NUM_BP-1:0] bp_coast,
    input logic [NUM_BP-1:0] bp_match,
    input logic              brk_pulse,
    input logic [NUM_BP-1:0] brk_src,
    input logic              tripped
);
    AST_MATCH_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |-> (bp_match == '0)); // R1

    AST_DIRECT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tripped && |(bp_match & ~bp_coast)) |=> brk_pulse); // R2

    AST_SRC_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse == (brk_src != '0)); // R11

    AST_QUIET_WHEN_TRIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |=> !brk_pulse); // R8

    AST_TRIP_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> tripped); // R8

    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !brk_pulse); // R9
endmodule

bind brk_coast_unit brk_coast_chk #(.NUM_BP(NUM_BP)) i_brk_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cyc_valid (cyc_valid),
    .bp_coast  (bp_coast),
    .bp_match  (bp_match),
    .brk_pulse (brk_pulse),
    .brk_src   (brk_src),
    .tripped   (tripped)
);

// File: tb/test_brk_coast_unit.sv
module test_brk_coast_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam logic [31:0] ARMW = 32'h1234_5600;
    localparam logic [31:0] ZW   = 32'h0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [NB-1:0][31:0] bp_value = '0;
    logic [NB-1:0][31:0] bp_care = '0;
    logic [NB-1:0] bp_coast = '0;
    logic [NB-1:0][2:0] bp_class = '0;
    logic [NB-1:0][7:0] bp_count = '0;
    logic [31:0] cyc_word = '0;
    logic cyc_valid = 1'b0;
    logic [4:0] ev_flags = '0;
    logic [2:0] ev_avail = '0;
    logic [NB-1:0] bp_match;
    logic brk_pulse;
    logic [NB-1:0] brk_src;

    brk_coast_unit i_brk_coast_unit (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .bp_value(bp_value), .bp_care(bp_care), .bp_coast(bp_coast),
        .bp_class(bp_class), .bp_count(bp_count),
        .cyc_word(cyc_word), .cyc_valid(cyc_valid),
        .ev_flags(ev_flags), .ev_avail(ev_avail),
        .bp_match(bp_match), .brk_pulse(brk_pulse), .brk_src(brk_src)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done = 0;
    string cur_req = "R9";
    int pulses = 0;
    logic [NB-1:0] last_src = '0;

    // reference model state
    bit m_armed [NB];
    int m_cnt [NB];
    bit m_trip = 0;
    bit exp_brk = 0;
    logic [NB-1:0] exp_src = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit m_hit(int b);
        return cyc_valid && ((cyc_word & bp_care[b]) == (bp_value[b] & bp_care[b]));
    endfunction

    function automatic bit m_qual(int b);
        bit ia, si, so;
        if (!cyc_valid) return 0;
        ia = ev_flags[2] && ev_avail[0];
        si = ev_flags[3] && ev_avail[1];
        so = ev_flags[4] && ev_avail[2];
        case (int'(bp_class[b]))
            0: return ev_flags[0];
            1: return ev_flags[1];
            2: return ia;
            3: return si;
            4: return so;
            5: return ev_flags[0] || ev_flags[1] || ia || si || so;
            default: return 0;
        endcase
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        logic [NB-1:0] f;
        f = '0;
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin m_armed[b] = 0; m_cnt[b] = 0; end
            m_trip = 0;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (enable && !m_trip) begin
                    if (!bp_coast[b]) f[b] = m_hit(b);
                    else f[b] = m_armed[b] && m_qual(b) && (m_cnt[b] == 1);
                end
            end
            for (int b = 0; b < NB; b++) begin
                if (!enable || m_trip) begin
                    m_armed[b] = 0; m_cnt[b] = 0;
                end else if (m_armed[b]) begin
                    if (m_qual(b)) begin
                        m_cnt[b] = m_cnt[b] - 1;
                        if (m_cnt[b] == 0) m_armed[b] = 0;
                    end
                end else if (bp_coast[b] && m_hit(b) && bp_count[b] != 0) begin
                    m_armed[b] = 1; m_cnt[b] = int'(bp_count[b]);
                end
            end
            m_trip = enable ? (m_trip || (f != 0)) : 0;
        end
        exp_brk = (f != 0);
        exp_src = f;
    end

    // per-clock comparison, away from the rising edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(bp_match[0] == m_hit(0) && bp_match[1] == m_hit(1), "R1 match",
                bp_match, {m_hit(1), m_hit(0)});
            chk(brk_pulse == exp_brk, {cur_req, " pulse"}, brk_pulse, exp_brk);
            chk(brk_src == exp_src, {cur_req, " src"}, brk_src, exp_src);
            if (brk_pulse) begin pulses++; last_src = brk_src; end
        end
    end

    task automatic drv(input logic [31:0] w, input bit v, input logic [4:0] ev);
        @(negedge clk); #1;
        cyc_word = w; cyc_valid = v; ev_flags = ev;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(ZW, 0, 5'b0);
    endtask

    // drop enable for a cycle, apply the slot setup, then re-enable
    task automatic setup(input string req, input bit c0, input logic [2:0] k0, input logic [7:0] n0,
                         input bit c1, input logic [2:0] k1, input logic [7:0] n1);
        @(negedge clk); #1;
        enable = 0; cyc_valid = 0; ev_flags = '0;
        bp_coast = {c1, c0}; bp_class = {k1, k0}; bp_count = {n1, n0};
        @(negedge clk); #1;
        enable = 1;
        cur_req = req;
        pulses = 0; last_src = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        cmp_on = 1;
        @(negedge clk); #1;
        // R9: reset state
        chk(brk_pulse == 0 && brk_src == 0, "R9 reset", {brk_pulse, brk_src}, 0);

        // R1: masked compare, enable low so no breaks (R9)
        bp_value[0] = ARMW; bp_care[0] = 32'hFFFF_FF00;
        bp_value[1] = 32'hFFFF_FFFF; bp_care[1] = 32'hFFFF_FFFF;
        cur_req = "R9";
        drv(ARMW, 1, 0); #2 chk(bp_match[0] == 1, "R1 exact", bp_match[0], 1);
        drv(ARMW ^ 32'h0001_0000, 1, 0); #2 chk(bp_match[0] == 0, "R1 cared bit", bp_match[0], 0);
        drv(ARMW | 32'h0000_00A5, 1, 0); #2 chk(bp_match[0] == 1, "R1 dont care", bp_match[0], 1);
        drv(ARMW, 0, 0); #2 chk(bp_match[0] == 0, "R1 valid low", bp_match[0], 0);
        idle(2);
        chk(pulses == 0, "R9 disabled", pulses, 0);

        // R2: direct break on slot 0; slot 1 parked
        bp_care[1] = 32'hFFFF_FFFF;
        setup("R2", 0, 0, 0, 1, 7, 1);
        drv(ARMW, 1, 0); idle(2);
        chk(pulses == 1 && last_src == 2'b01, "R2 direct", {pulses, last_src}, {32'd1, 2'b01});

        // R8: tripped, then re-enabled
        cur_req = "R8"; pulses = 0;
        drv(ARMW, 1, 0); drv(ARMW, 1, 0); idle(2);
        chk(pulses == 0, "R8 tripped", pulses, 0);
        setup("R8", 0, 0, 0, 1, 7, 1);
        drv(ARMW, 1, 0); idle(2);
        chk(pulses == 1, "R8 reopen", pulses, 1);

        // R3: coast slot 1 on fetch, n=3; arming cycle event ignored
        bp_value[1] = ARMW; bp_care[1] = 32'hFFFF_FFFF;
        bp_care[0] = 32'hFFFF_FFFF; bp_value[0] = 32'hDEAD_BEEF;
        setup("R3", 1, 7, 1, 1, 0, 3);
        drv(ARMW, 1, 5'b00001);
        drv(ZW, 1, 5'b00001); drv(ZW, 1, 5'b00010); drv(ZW, 1, 5'b00001);
        idle(2);
        chk(pulses == 0, "R3 early", pulses, 0);
        drv(ZW, 1, 5'b00001); idle(2);
        chk(pulses == 1 && last_src == 2'b10, "R3 coast", {pulses, last_src}, {32'd1, 2'b10});

        // R7: re-match while coasting does not reload
        setup("R7", 1, 7, 1, 1, 1, 2);
        drv(ARMW, 1, 0); drv(ZW, 1, 5'b00010); drv(ARMW, 1, 0); drv(ZW, 1, 5'b00010); idle(2);
        chk(pulses == 1, "R7 no reload", pulses, 1);

        // R6: zero count never arms
        setup("R6", 1, 7, 1, 1, 0, 0);
        drv(ARMW, 1, 0);
        for (int i = 0; i < 5; i++) drv(ZW, 1, 5'b00001);
        idle(2);
        chk(pulses == 0, "R6 zero count", pulses, 0);

        // R5: int ack unavailable, then available
        setup("R5", 1, 7, 1, 1, 2, 1);
        ev_avail = 3'b110;
        drv(ARMW, 1, 0);
        for (int i = 0; i < 4; i++) drv(ZW, 1, 5'b00100);
        idle(2);
        chk(pulses == 0, "R5 unavailable", pulses, 0);
        ev_avail = 3'b111;
        drv(ZW, 1, 5'b00100); idle(2);
        chk(pulses == 1, "R5 available", pulses, 1);

        // R4: off code never counts; any-class counts mixed kinds
        setup("R4", 1, 7, 1, 1, 6, 1);
        drv(ARMW, 1, 0);
        for (int i = 0; i < 5; i++) drv(ZW, 1, 5'b11111);
        idle(2);
        chk(pulses == 0, "R4 off code", pulses, 0);
        setup("R4", 1, 7, 1, 1, 5, 3);
        ev_avail = 3'b000;
        drv(ARMW, 1, 0);
        drv(ZW, 1, 5'b10000); drv(ZW, 1, 5'b00010); drv(ZW, 1, 5'b01000);
        drv(ZW, 1, 5'b00001); idle(1);
        chk(pulses == 0, "R4 any gated", pulses, 0);
        drv(ZW, 1, 5'b00001); idle(2);
        chk(pulses == 1, "R4 any", pulses, 1);
        ev_avail = 3'b111;

        // R10: events on invalid cycles ignored
        setup("R10", 1, 7, 1, 1, 0, 2);
        drv(ARMW, 1, 0);
        for (int i = 0; i < 4; i++) drv(ZW, 0, 5'b00001);
        drv(ZW, 1, 5'b00001); idle(2);
        chk(pulses == 0, "R10 invalid events", pulses, 0);
        drv(ZW, 1, 5'b00001); idle(2);
        chk(pulses == 1, "R10 valid events", pulses, 1);

        // R11: both slots direct, same word
        bp_value[0] = ARMW;
        setup("R11", 0, 0, 0, 0, 0, 0);
        drv(ARMW, 1, 0); idle(2);
        chk(pulses == 1 && last_src == 2'b11, "R11 both", {pulses, last_src}, {32'd1, 2'b11});

        idle(2);
        finish_run();
    end
endmodule